// File: doc/BRIEF.md
# Peripheral Window Bus Adapter

This block sits between a CPU data port and a bank of 16-bit peripheral registers. A 4 KB window at the top of a 24-bit address space (0xFFF000 to 0xFFFFFF) is claimed for peripherals. Only 1 KB of that window is backed by registers. The rest of the window repeats that kilobyte, so the adapter uses just the low ten address bits to pick a register. Address bit 0 is always dropped, because every register sits on an even address.

CPU accesses may be 8, 16 or 32 bits wide. The adapter turns each one into one or two 16-bit peripheral cycles. A table built into the block, indexed by register number, marks each register as present or reserved, and marks a present register as byte-wide or halfword-only. These two marks decide which byte lanes are used and whether a peripheral cycle is issued at all.

A 32-bit access becomes two halfword cycles: first at address n, then at n+2. An instruction fetch into the window is refused. No peripheral cycle is issued for it, and a fault pulse is raised together with ready.

Top module: `pwin_adapter`

## Requirements
- R1: Only requests whose address lies in 0xFFF000..0xFFFFFF are served. For any other address the block issues no peripheral cycle and never raises cpu_ready.
- R2: The peripheral address is formed from cpu_addr[9:0] with bit 0 cleared. Window addresses that share their low ten bits therefore reach the same register (0xFFF810 reaches 0x010).
- R3: An access to an odd address 2n+1 reaches the register at 2n. per_addr[0] is always 0.
- R4: A halfword read of a byte-wide register returns its low 8 bits in cpu_rdata[7:0], with cpu_rdata[31:8] zero. A byte read returns the register's low byte in bits 7:0 and zero in bits 31:8.
- R5: A write to a byte-wide register drives per_wdata as {8'h00, data[7:0]}.
- R6: A word access (cpu_size 2'b10) at n issues two cycles in order. The first goes to n and carries bits 15:0. The second goes to n+2, modulo 1 KB, and carries bits 31:16. Read data is returned as {second, first}.
- R7: A fetch (cpu_fetch=1) into the window issues no peripheral cycle. fetch_fault rises for exactly one cycle, in the same cycle as cpu_ready, one clock after the request is taken.
- R8: For a reserved register, a read returns zero and a write is dropped. No peripheral cycle is issued and no fault is raised. The handshake still completes. For a word access, each half is treated on its own.
- R9: cpu_ready is high for exactly one cycle. It rises in the cycle after the final acknowledged peripheral cycle, and never while per_req is high. With zero peripheral wait states, latency is 2 clocks for a single access and 3 clocks for a word access. Each wait state adds one clock per half.
- R10: While per_req is high and per_ack is low, per_req, per_addr, per_we and per_wdata stay unchanged.
- R11: Byte accesses to a halfword-only register work as follows. A read returns the low byte. A write is dropped with no peripheral cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, held until cpu_ready; changed in the ready cycle |
| cpu_addr | input | 24 | Byte address |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_fetch | input | 1 | Request is an instruction fetch |
| cpu_wdata | input | 32 | Write data, byte data in bits 7:0 |
| cpu_ready | output | 1 | One-cycle completion |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| fetch_fault | output | 1 | Refused fetch, pulses with cpu_ready |
| per_req | output | 1 | Peripheral cycle request |
| per_addr | output | 10 | Even register byte address |
| per_we | output | 1 | Peripheral write |
| per_wdata | output | 16 | Peripheral write data |
| per_ack | input | 1 | Peripheral completes the cycle |
| per_rdata | input | 16 | Peripheral read data, valid with per_ack |

## Verification
The request is taken at the first edge. The bench then counts clock edges until cpu_ready is seen at a falling edge, and compares that count with the latency that R9 gives for the access width and the number of wait states the peripheral model inserts. A refused fetch is due after one edge. A reserved half costs the same single edge as an acknowledged one. cpu_rdata and fetch_fault are sampled only in the falling edge where ready is seen. Peripheral addresses and data are logged at the acknowledging rising edge, so their order is checked cycle for cycle.

// File: rtl/pwin_adapter.sv
module pwin_adapter #(
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int RW       = 16,
  parameter int PA_W     = 10,
  parameter int WIN_BITS = 12,
  parameter logic [AW-1:0] WIN_BASE = 24'hFFF000,
  parameter logic [(1<<(PA_W-1))-1:0] VALID_MAP = {{384{1'b0}}, {128{1'b1}}},
  parameter logic [(1<<(PA_W-1))-1:0] BYTE_MAP  = {{384{1'b0}}, {64{1'b1}}, {64{1'b0}}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [1:0]      cpu_size,
  input  logic            cpu_we,
  input  logic            cpu_fetch,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_ready,
  output logic [DW-1:0]   cpu_rdata,
  output logic            fetch_fault,
  output logic            per_req,
  output logic [PA_W-1:0] per_addr,
  output logic            per_we,
  output logic [RW-1:0]   per_wdata,
  input  logic            per_ack,
  input  logic [RW-1:0]   per_rdata
);
  localparam int IW = PA_W - 1;
  localparam int BW = RW / 2;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} state_t;

  state_t        state;
  logic [IW-1:0] idx_q;
  logic [1:0]    sz_q;
  logic          we_q, ph_q, flt_q;
  logic [DW-1:0] wd_q, rd_q;

  logic          hit, vld, byt, skip, last, step, lane8;
  logic [IW-1:0] cur_idx;
  logic [RW-1:0] half_w, lane_r;

  assign hit     = cpu_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS];
  assign cur_idx = idx_q + IW'(ph_q);
  assign vld     = VALID_MAP[cur_idx];
  assign byt     = BYTE_MAP[cur_idx];
  assign skip    = !vld || (sz_q == SZ_BYTE && we_q && !byt);
  assign last    = (sz_q != SZ_WORD) || ph_q;
  assign step    = (state == S_ACC) && (skip || per_ack);
  assign lane8   = byt || (sz_q == SZ_BYTE);

  assign half_w  = ph_q ? wd_q[DW-1:RW] : wd_q[RW-1:0];
  assign lane_r  = lane8 ? {{BW{1'b0}}, per_rdata[BW-1:0]} : per_rdata;

  assign per_req     = (state == S_ACC) && !skip;
  assign per_addr    = {cur_idx, 1'b0};
  assign per_we      = we_q;
  assign per_wdata   = lane8 ? {{BW{1'b0}}, half_w[BW-1:0]} : half_w;
  assign cpu_ready   = (state == S_DONE);
  assign cpu_rdata   = rd_q;
  assign fetch_fault = (state == S_DONE) && flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx_q <= '0;
      sz_q  <= '0;
      we_q  <= 1'b0;
      ph_q  <= 1'b0;
      flt_q <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req && hit) begin
          idx_q <= cpu_addr[PA_W-1:1];
          sz_q  <= cpu_size;
          we_q  <= cpu_we;
          wd_q  <= cpu_wdata;
          ph_q  <= 1'b0;
          rd_q  <= '0;
          flt_q <= cpu_fetch;
          state <= cpu_fetch ? S_DONE : S_ACC;
        end
        S_ACC: if (step) begin
          if (!we_q && !skip) begin
            if (ph_q) rd_q[DW-1:RW] <= lane_r;
            else      rd_q[RW-1:0]  <= lane_r;
          end
          if (last) state <= S_DONE;
          else      ph_q  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwin_adapter_chk.sv
module pwin_adapter_chk #(
  parameter int PA_W = 10,
  parameter int RW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_ready,
  input logic            fetch_fault,
  input logic            per_req,
  input logic            per_ack,
  input logic            per_we,
  input logic [PA_W-1:0] per_addr,
  input logic [RW-1:0]   per_wdata
);
  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> !per_addr[0]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack |=> per_req && $stable(per_addr) && $stable(per_we) && $stable(per_wdata));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_no_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> !cpu_ready);

  p_fault_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> cpu_ready && !per_req);

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |=> !fetch_fault);
endmodule

bind pwin_adapter pwin_adapter_chk #(.PA_W(PA_W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .fetch_fault(fetch_fault),
  .per_req(per_req), .per_ack(per_ack), .per_we(per_we),
  .per_addr(per_addr), .per_wdata(per_wdata)
);

// File: tb/pwin_adapter_tb.sv
module pwin_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_fetch = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, fetch_fault, per_req, per_we, per_ack;
  logic [31:0] cpu_rdata;
  logic [9:0]  per_addr;
  logic [15:0] per_wdata, per_rdata;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwin_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_we(cpu_we), .cpu_fetch(cpu_fetch),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .fetch_fault(fetch_fault), .per_req(per_req), .per_addr(per_addr),
    .per_we(per_we), .per_wdata(per_wdata), .per_ack(per_ack),
    .per_rdata(per_rdata)
  );

  logic [15:0] mem [512];
  int          wait_n = 0;
  int          wcnt = 0;
  int          acks = 0;
  logic [9:0]  log_a [8];
  logic [15:0] log_d [8];

  assign per_ack   = per_req && (wcnt == wait_n);
  assign per_rdata = mem[per_addr[9:1]];

  always @(posedge clk) begin
    if (per_req && !per_ack) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (per_req && per_ack) begin
      log_a[acks % 8] <= per_addr;
      log_d[acks % 8] <= per_wdata;
      if (per_we) mem[per_addr[9:1]] <= per_wdata;
      acks <= acks + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic [1:0] sz, input logic we,
                        input logic fe, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output logic flt);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_fetch = fe; cpu_wdata = wd;
    cyc = 0; rd = 'x; flt = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cyc++;
      if (cpu_ready) begin
        rd = cpu_rdata; flt = fetch_fault;
        break;
      end
    end
    if (!cpu_ready) cyc = -1;
    cpu_req = 1'b0; cpu_fetch = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset ready", {31'b0, cpu_ready}, 0);
    chk("R7 reset fault", {31'b0, fetch_fault}, 0);
    chk("R9 reset per_req", {31'b0, per_req}, 0);
  endtask

  task automatic t_halfword;
    logic [31:0] rd; int c; logic f;
    mem[8] = 16'hA5C3;
    access(24'hFFF010, 2'b01, 1'b0, 1'b0, 0, rd, c, f);
    chk("R9 half latency", c, 2);
    chk("R2 half read", rd, 32'h0000A5C3);
    access(24'hFFF810, 2'b01, 1'b0, 1'b0, 0, rd, c, f);
    chk("R2 alias read", rd, 32'h0000A5C3);
    chk("R2 alias addr", {22'b0, log_a[(acks-1)%8]}, 32'h010);
  endtask

  task automatic t_bytes;
    logic [31:0] rd; int c; logic f;
    mem[64] = 16'hAB55; mem[65] = 16'hCC77;
    access(24'hFFF081, 2'b00, 1'b0, 1'b0, 0, rd, c, f);
    chk("R3 odd byte read", rd, 32'h55);
    chk("R3 odd byte addr", {22'b0, log_a[(acks-1)%8]}, 32'h080);
    access(24'hFFF082, 2'b01, 1'b0, 1'b0, 0, rd, c, f);
    chk("R4 half read byte reg", rd, 32'h77);
    access(24'hFFF084, 2'b01, 1'b1, 1'b0, 32'h0000BEEF, rd, c, f);
    chk("R5 half write byte reg", {16'b0, log_d[(acks-1)%8]}, 32'h00EF);
  endtask

  task automatic t_word;
    logic [31:0] rd; int c; logic f; int a0;
    a0 = acks;
    access(24'hFFF010, 2'b10, 1'b1, 1'b0, 32'h12345678, rd, c, f);
    chk("R6 word write latency", c, 3);
    chk("R6 two cycles", acks - a0, 2);
    chk("R6 first addr", {22'b0, log_a[a0%8]}, 32'h010);
    chk("R6 first data", {16'b0, log_d[a0%8]}, 32'h5678);
    chk("R6 second addr", {22'b0, log_a[(a0+1)%8]}, 32'h012);
    chk("R6 second data", {16'b0, log_d[(a0+1)%8]}, 32'h1234);
    mem[63] = 16'h4321;
    access(24'hFFF07E, 2'b10, 1'b0, 1'b0, 0, rd, c, f);
    chk("R6 word read mixed", rd, 32'h00554321);
  endtask

  task automatic t_waits;
    logic [31:0] rd; int c; logic f;
    wait_n = 2;
    access(24'hFFF010, 2'b01, 1'b0, 1'b0, 0, rd, c, f);
    chk("R9 half wait2 latency", c, 4);
    wait_n = 1;
    access(24'hFFF010, 2'b10, 1'b0, 1'b0, 0, rd, c, f);
    chk("R9 word wait1 latency", c, 5);
    chk("R10 word read under waits", rd, 32'h12345678);
    wait_n = 0;
  endtask

  task automatic t_fetch;
    logic [31:0] rd; int c; logic f; int a0;
    a0 = acks;
    access(24'hFFF010, 2'b10, 1'b0, 1'b1, 0, rd, c, f);
    chk("R7 fetch latency", c, 1);
    chk("R7 fetch fault", {31'b0, f}, 1);
    chk("R7 fetch no cycle", acks - a0, 0);
    @(negedge clk);
    chk("R7 fault one cycle", {31'b0, fetch_fault}, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] rd; int c; logic f; int a0;
    mem[256] = 16'h1111; mem[127] = 16'h9988; mem[2] = 16'h9A3C;
    a0 = acks;
    access(24'hFFF200, 2'b01, 1'b0, 1'b0, 0, rd, c, f);
    chk("R8 reserved read zero", rd, 0);
    chk("R8 reserved latency", c, 2);
    access(24'hFFF200, 2'b01, 1'b1, 1'b0, 32'h2222, rd, c, f);
    chk("R8 reserved write dropped", acks - a0, 0);
    chk("R8 reserved no fault", {31'b0, f}, 0);
    access(24'hFFF0FE, 2'b10, 1'b0, 1'b0, 0, rd, c, f);
    chk("R8 word half reserved", rd, 32'h00000088);
    chk("R8 word half reserved cycles", acks - a0, 1);
    access(24'hFFF004, 2'b00, 1'b1, 1'b0, 32'h77, rd, c, f);
    chk("R11 byte write halfword reg dropped", acks - a0, 1);
    access(24'hFFF005, 2'b00, 1'b0, 1'b0, 0, rd, c, f);
    chk("R11 byte read halfword reg", rd, 32'h3C);
  endtask

  task automatic t_outside;
    int a0; logic seen;
    a0 = acks; seen = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 24'h001010; cpu_size = 2'b01; cpu_we = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cpu_ready || per_req) seen = 1'b1;
    end
    cpu_req = 1'b0;
    chk("R1 outside no ready", {31'b0, seen}, 0);
    chk("R1 outside no cycle", acks - a0, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_halfword();
    t_bytes();
    t_word();
    t_waits();
    t_fetch();
    t_reserved();
    t_outside();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule